// File: doc/BRIEF.md
# Audio Sample-Rate Speed Class Selector

This block picks the sampling-speed class of one audio port. There are three classes: normal (32 to 48 kHz), double (64 to 96 kHz) and quad (128 to 192 kHz). It runs in the master-clock domain and watches a frame clock that has already been synchronized into that domain.

With the mode select low, a 2-bit software field sets the class directly. With the mode select high, the block counts master-clock cycles between rising frame-clock edges. It maps the count to a class, and a new class is adopted only after two consecutive frames agree. The ADC path only runs at normal speed, so the block requests ADC power-down whenever the class is double or quad. The DAC path keeps running at every class.

The block also decodes the 3-bit master-clock ratio selection used when the port generates its own clocks. It reports the ratio and whether that ratio is legal for the class now in force.

Top module: `speed_mode_sel`

## Requirements
- R1: With `auto_mode_i`=0, `man_speed_i` values 00, 01 and 10 load `speed_o` with 00 (normal), 01 (double) and 10 (quad) respectively, visible one clock later.
- R2: With `auto_mode_i`=0 and `man_speed_i`=11 (no valid speed), `speed_o` keeps its value and both `adc_pd_o` and `dac_pd_o` are 1 from the next clock.
- R3: With `auto_mode_i`=1, a frame period within ±2 master clocks of 128 or 192 classifies as quad, of 256 or 384 as double, and of 512 or 768 as normal. The period is measured from one rising frame edge to the next.
- R4: In auto mode a class is committed to `speed_o` only on the second of two consecutive measured frames with the same class. A single frame, or two differing frames, leaves `speed_o` unchanged. `speed_o` changes only in the clock after a rising frame edge.
- R5: A measured period that matches no nominal ratio sets `ratio_bad_o`, keeps `speed_o` and discards the pending candidate. The next valid measurement clears `ratio_bad_o`.
- R6: `adc_pd_o` is 1 whenever `speed_o` is not 00. `dac_pd_o` is never 1 unless `adc_pd_o` is also 1, and it stays 0 at double and quad speed.
- R7: While `rst_ni`=0 or `port_rst_i`=1, both power-down outputs are 1. The same reset sets `speed_o` to 00, clears `ratio_bad_o` and clears the measurement history, so the first rising frame edge after reset only starts a measurement.
- R8: `mst_ratio_sel_i` decodes on `mst_ratio_o` as 000=256, 001=384, 010=512, 011=768, 100=128, 101=192, and 11x=0 (not available).
- R9: `mst_ratio_ok_o` is 1 only when the ratio is legal for `speed_o`: 512 and 768 at normal, 128 and 192 at double or quad, 256 and 384 at normal or double. It is 0 for 11x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| port_rst_i | input | 1 | Synchronous port reset, holds both paths down |
| frame_clk_i | input | 1 | Frame clock, already synchronized to clk_i |
| auto_mode_i | input | 1 | 1 = measure the ratio, 0 = use man_speed_i |
| man_speed_i | input | 2 | Manual speed field |
| mst_ratio_sel_i | input | 3 | Master-clock ratio selection for clock-master use |
| speed_o | output | 2 | Speed class: 00 normal, 01 double, 10 quad |
| adc_pd_o | output | 1 | ADC power-down request |
| dac_pd_o | output | 1 | DAC power-down request |
| ratio_bad_o | output | 1 | Last measured period matched no nominal ratio |
| mst_ratio_o | output | 10 | Decoded master clocks per frame, 0 if not available |
| mst_ratio_ok_o | output | 1 | Selected ratio is legal for speed_o |

## Verification
A corrupted period counter shows up at the first rising frame edge after the fault. It either raises `ratio_bad_o` at once or commits a wrong class to `speed_o` one frame later. A stale or wrong candidate register shows as `speed_o` changing after a single frame, or failing to change after two. Either way it appears within two frame periods as a wrong `speed_o` or `adc_pd_o`. Faults in the manual path or in the ratio decoder are visible in the next clock or immediately, so the bench compares every output against its model on every clock.

// File: rtl/spdsel_pkg.sv
`timescale 1ns/1ps
package spdsel_pkg;

  typedef enum logic [1:0] {
    SPD_NORMAL = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_QUAD   = 2'b10,
    SPD_NONE   = 2'b11
  } speed_e;

  localparam int NUM_NOMINAL = 6;

  // nominal master clocks per frame, ascending
  function automatic int nominal_ratio(input int idx);
    case (idx)
      0:       return 128;
      1:       return 192;
      2:       return 256;
      3:       return 384;
      4:       return 512;
      default: return 768;
    endcase
  endfunction

  function automatic speed_e nominal_class(input int idx);
    if (idx < 2)      return SPD_QUAD;
    else if (idx < 4) return SPD_DOUBLE;
    else              return SPD_NORMAL;
  endfunction

endpackage

// File: rtl/spdsel_period_meter.sv
`timescale 1ns/1ps
module spdsel_period_meter #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             frame_clk_i,
  output logic             meas_vld_o,
  output logic [CNT_W-1:0] meas_cnt_o
);

  logic             frame_q;
  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise;

  assign rise       = frame_clk_i & ~frame_q;
  assign meas_vld_o = rise & armed_q;
  assign meas_cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (clr_i) begin
      frame_q <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      frame_q <= frame_clk_i;
      if (rise) begin
        armed_q <= 1'b1;
        cnt_q   <= CNT_W'(1);
      end else if (cnt_q != '1) begin
        cnt_q <= cnt_q + CNT_W'(1);   // saturates, out-of-range reads as invalid
      end
    end
  end

endmodule

// File: rtl/spdsel_ratio_class.sv
`timescale 1ns/1ps
module spdsel_ratio_class
  import spdsel_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int TOL   = 2
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic             hit_o,
  output speed_e           class_o
);

  logic [NUM_NOMINAL-1:0] match;

  for (genvar g = 0; g < NUM_NOMINAL; g++) begin : g_nom
    localparam logic [CNT_W-1:0] LO = CNT_W'(nominal_ratio(g) - TOL);
    localparam logic [CNT_W-1:0] HI = CNT_W'(nominal_ratio(g) + TOL);
    assign match[g] = (cnt_i >= LO) && (cnt_i <= HI);
  end

  always_comb begin
    hit_o   = |match;
    class_o = SPD_NORMAL;
    for (int i = 0; i < NUM_NOMINAL; i++) begin
      if (match[i]) class_o = nominal_class(i);
    end
  end

endmodule

// File: rtl/spdsel_mst_decode.sv
`timescale 1ns/1ps
module spdsel_mst_decode
  import spdsel_pkg::*;
#(
  parameter int RATIO_W = 10
) (
  input  logic [2:0]         sel_i,
  input  speed_e             speed_i,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               ok_o
);

  logic is_n, is_d, is_q;

  assign is_n = (speed_i == SPD_NORMAL);
  assign is_d = (speed_i == SPD_DOUBLE);
  assign is_q = (speed_i == SPD_QUAD);

  always_comb begin
    ratio_o = '0;
    ok_o    = 1'b0;
    case (sel_i)
      3'b000: begin ratio_o = RATIO_W'(256); ok_o = is_n | is_d; end
      3'b001: begin ratio_o = RATIO_W'(384); ok_o = is_n | is_d; end
      3'b010: begin ratio_o = RATIO_W'(512); ok_o = is_n;        end
      3'b011: begin ratio_o = RATIO_W'(768); ok_o = is_n;        end
      3'b100: begin ratio_o = RATIO_W'(128); ok_o = is_d | is_q; end
      3'b101: begin ratio_o = RATIO_W'(192); ok_o = is_d | is_q; end
      default: begin ratio_o = '0; ok_o = 1'b0; end
    endcase
  end

endmodule

// File: rtl/speed_mode_sel.sv
`timescale 1ns/1ps
module speed_mode_sel
  import spdsel_pkg::*;
#(
  parameter int TOL       = 2,
  parameter int MAX_RATIO = 768
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              port_rst_i,
  input  logic                              frame_clk_i,
  input  logic                              auto_mode_i,
  input  logic [1:0]                        man_speed_i,
  input  logic [2:0]                        mst_ratio_sel_i,
  output logic [1:0]                        speed_o,
  output logic                              adc_pd_o,
  output logic                              dac_pd_o,
  output logic                              ratio_bad_o,
  output logic [$clog2(MAX_RATIO+1)-1:0]    mst_ratio_o,
  output logic                              mst_ratio_ok_o
);

  localparam int CNT_W   = $clog2(MAX_RATIO + TOL + 1);
  localparam int RATIO_W = $clog2(MAX_RATIO + 1);

  logic             meas_vld;
  logic [CNT_W-1:0] meas_cnt;
  logic             cls_hit;
  speed_e           cls;

  speed_e speed_q;
  speed_e cand_q;
  logic   cand_vld_q;
  logic   bad_q;
  logic   na_q;

  spdsel_period_meter #(.CNT_W(CNT_W)) u_meter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (port_rst_i),
    .frame_clk_i (frame_clk_i),
    .meas_vld_o  (meas_vld),
    .meas_cnt_o  (meas_cnt)
  );

  spdsel_ratio_class #(.CNT_W(CNT_W), .TOL(TOL)) u_class (
    .cnt_i   (meas_cnt),
    .hit_o   (cls_hit),
    .class_o (cls)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      speed_q    <= SPD_NORMAL;
      cand_q     <= SPD_NORMAL;
      cand_vld_q <= 1'b0;
      bad_q      <= 1'b0;
      na_q       <= 1'b0;
    end else if (port_rst_i) begin
      speed_q    <= SPD_NORMAL;
      cand_q     <= SPD_NORMAL;
      cand_vld_q <= 1'b0;
      bad_q      <= 1'b0;
      na_q       <= 1'b0;
    end else begin
      if (meas_vld) begin
        if (cls_hit) begin
          bad_q      <= 1'b0;
          cand_q     <= cls;
          cand_vld_q <= 1'b1;
          // second agreeing frame commits
          if (auto_mode_i && cand_vld_q && (cand_q == cls)) speed_q <= cls;
        end else begin
          bad_q      <= 1'b1;
          cand_vld_q <= 1'b0;
        end
      end
      if (!auto_mode_i) begin
        na_q <= (man_speed_i == 2'b11);
        if (man_speed_i != 2'b11) speed_q <= speed_e'(man_speed_i);
      end else begin
        na_q <= 1'b0;
      end
    end
  end

  spdsel_mst_decode #(.RATIO_W(RATIO_W)) u_mst (
    .sel_i   (mst_ratio_sel_i),
    .speed_i (speed_q),
    .ratio_o (mst_ratio_o),
    .ok_o    (mst_ratio_ok_o)
  );

  assign speed_o     = speed_q;
  assign ratio_bad_o = bad_q;
  assign dac_pd_o    = ~rst_ni | port_rst_i | na_q;
  assign adc_pd_o    = ~rst_ni | port_rst_i | na_q | (speed_q != SPD_NORMAL);

endmodule

// File: rtl/speed_mode_sel_chk.sv
`timescale 1ns/1ps
module speed_mode_sel_chk #(
  parameter int RATIO_W = 10
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               port_rst_i,
  input logic               frame_clk_i,
  input logic               auto_mode_i,
  input logic [1:0]         man_speed_i,
  input logic [1:0]         speed_o,
  input logic               adc_pd_o,
  input logic               dac_pd_o,
  input logic               ratio_bad_o,
  input logic [RATIO_W-1:0] mst_ratio_o,
  input logic               mst_ratio_ok_o
);

  // R1
  manual_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!port_rst_i && !auto_mode_i && man_speed_i != 2'b11) |=> (speed_o == $past(man_speed_i)));

  // R2
  manual_na_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!port_rst_i && !auto_mode_i && man_speed_i == 2'b11) |=> (dac_pd_o && adc_pd_o && $stable(speed_o)));

  // R4
  commit_on_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($changed(speed_o) && $past(auto_mode_i) && !$past(port_rst_i)) |-> ($past(frame_clk_i) && !$past(frame_clk_i, 2)));

  // R6
  pd_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_pd_o |-> adc_pd_o);

  // R7
  port_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_rst_i |=> (speed_o == 2'b00 && !ratio_bad_o));

  // R9
  mst_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_ratio_ok_o |-> (mst_ratio_o != '0));

endmodule

bind speed_mode_sel speed_mode_sel_chk #(.RATIO_W(RATIO_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .port_rst_i     (port_rst_i),
  .frame_clk_i    (frame_clk_i),
  .auto_mode_i    (auto_mode_i),
  .man_speed_i    (man_speed_i),
  .speed_o        (speed_o),
  .adc_pd_o       (adc_pd_o),
  .dac_pd_o       (dac_pd_o),
  .ratio_bad_o    (ratio_bad_o),
  .mst_ratio_o    (mst_ratio_o),
  .mst_ratio_ok_o (mst_ratio_ok_o)
);

// File: tb/tb_speed_mode_sel.sv
`timescale 1ns/1ps
module tb_speed_mode_sel;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       port_rst = 1'b1;
  logic       frame = 1'b0;
  logic       auto_m = 1'b0;
  logic [1:0] man = 2'b00;
  logic [2:0] msel = 3'b000;
  logic [1:0] speed;
  logic       adc_pd, dac_pd, bad, mok;
  logic [9:0] mratio;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  speed_mode_sel dut (
    .clk_i(clk), .rst_ni(rst_n), .port_rst_i(port_rst), .frame_clk_i(frame),
    .auto_mode_i(auto_m), .man_speed_i(man), .mst_ratio_sel_i(msel),
    .speed_o(speed), .adc_pd_o(adc_pd), .dac_pd_o(dac_pd), .ratio_bad_o(bad),
    .mst_ratio_o(mratio), .mst_ratio_ok_o(mok)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // behavioural reference model
  int m_speed, m_cand, m_bad, m_na, m_prev, m_last, m_cyc;

  function automatic int classify(input int p);
    int noms[6] = '{128, 192, 256, 384, 512, 768};
    int cls[6]  = '{2, 2, 1, 1, 0, 0};
    for (int i = 0; i < 6; i++)
      if (p >= noms[i] - 2 && p <= noms[i] + 2) return cls[i];
    return -1;
  endfunction

  task automatic model_clear();
    m_speed = 0; m_cand = -1; m_bad = 0; m_na = 0; m_prev = 0; m_last = -1;
  endtask

  initial begin
    model_clear();
    m_cyc = 0;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_clear();
    else begin
      m_cyc++;
      if (port_rst) model_clear();
      else begin
        if (frame && !m_prev) begin
          if (m_last >= 0) begin
            int c;
            c = classify(m_cyc - m_last);
            if (c >= 0) begin
              m_bad = 0;
              if (auto_m && m_cand == c) m_speed = c;
              m_cand = c;
            end else begin
              m_bad = 1;
              m_cand = -1;
            end
          end
          m_last = m_cyc;
        end
        m_prev = frame;
        if (!auto_m) begin
          m_na = (man == 2'b11);
          if (man != 2'b11) m_speed = man;
        end else m_na = 0;
      end
    end
  end

  function automatic int exp_ratio(input logic [2:0] s);
    case (s)
      3'd0: return 256; 3'd1: return 384; 3'd2: return 512; 3'd3: return 768;
      3'd4: return 128; 3'd5: return 192; default: return 0;
    endcase
  endfunction

  function automatic int exp_ok(input logic [2:0] s, input int sp);
    case (s)
      3'd0, 3'd1: return (sp == 0 || sp == 1) ? 1 : 0;
      3'd2, 3'd3: return (sp == 0) ? 1 : 0;
      3'd4, 3'd5: return (sp == 1 || sp == 2) ? 1 : 0;
      default:    return 0;
    endcase
  endfunction

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      int rst_any, e_dac, e_adc;
      rst_any = (!rst_n || port_rst) ? 1 : 0;
      e_dac = (rst_any || m_na) ? 1 : 0;
      e_adc = (e_dac || m_speed != 0) ? 1 : 0;
      chk(auto_m ? "R4" : "R1", "speed_o", int'(speed), m_speed);
      chk("R6", "adc_pd_o", int'(adc_pd), e_adc);
      chk("R2", "dac_pd_o", int'(dac_pd), e_dac);
      chk("R5", "ratio_bad_o", int'(bad), m_bad);
      chk("R8", "mst_ratio_o", int'(mratio), exp_ratio(msel));
      chk("R9", "mst_ratio_ok_o", int'(mok), exp_ok(msel, m_speed));
    end
  end

  task automatic step(input int k);
    repeat (k) begin @(posedge clk); #2; end
  endtask

  task automatic frames(input int p, input int n);
    for (int i = 0; i < n; i++) begin
      frame = 1'b1; step(p / 2);
      frame = 1'b0; step(p - p / 2);
    end
  endtask

  task automatic at_neg();
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    at_neg();
    chk("R7", "adc_pd_o in reset", int'(adc_pd), 1);
    chk("R7", "dac_pd_o in reset", int'(dac_pd), 1);
    chk("R7", "speed_o in reset", int'(speed), 0);
    @(posedge clk); #2; rst_n = 1'b1;
    step(2);
    at_neg();
    chk("R7", "dac_pd_o port reset", int'(dac_pd), 1);
    @(posedge clk); #2; port_rst = 1'b0;
    step(2);
    at_neg();
    chk("R7", "dac_pd_o released", int'(dac_pd), 0);

    // manual mode
    @(posedge clk); #2; man = 2'b01; step(1);
    at_neg();
    chk("R1", "speed double", int'(speed), 1);
    chk("R6", "adc_pd at double", int'(adc_pd), 1);
    chk("R6", "dac_pd at double", int'(dac_pd), 0);
    @(posedge clk); #2; man = 2'b10; step(1);
    at_neg();
    chk("R1", "speed quad", int'(speed), 2);
    @(posedge clk); #2; man = 2'b11; step(2);
    at_neg();
    chk("R2", "speed held on 11", int'(speed), 2);
    chk("R2", "dac_pd on 11", int'(dac_pd), 1);
    @(posedge clk); #2; man = 2'b00; step(1);
    at_neg();
    chk("R1", "speed normal", int'(speed), 0);
    chk("R6", "adc_pd at normal", int'(adc_pd), 0);

    // master ratio decode at normal speed
    for (int s = 0; s < 8; s++) begin
      @(posedge clk); #2; msel = 3'(s);
      at_neg();
      chk("R8", "mst ratio", int'(mratio), exp_ratio(3'(s)));
      chk("R9", "mst ok at normal", int'(mok), (s < 4) ? 1 : 0);
    end
    @(posedge clk); #2; msel = 3'b000;

    // auto mode
    auto_m = 1'b1;
    frames(256, 4);
    at_neg();
    chk("R3", "256 -> double", int'(speed), 1);
    frames(130, 3);
    at_neg();
    chk("R3", "130 -> quad", int'(speed), 2);
    chk("R6", "adc_pd quad", int'(adc_pd), 1);
    chk("R6", "dac_pd quad", int'(dac_pd), 0);
    msel = 3'b100; #1;
    chk("R9", "128fs ok at quad", int'(mok), 1);
    msel = 3'b010; #1;
    chk("R9", "512fs not ok at quad", int'(mok), 0);
    msel = 3'b000;
    frames(770, 3);
    at_neg();
    chk("R3", "770 -> normal", int'(speed), 0);

    frames(192, 1); frames(384, 1); frames(770, 1);
    at_neg();
    chk("R4", "differing frames no commit", int'(speed), 0);
    frames(770, 2);
    frames(256, 1); frames(256, 1);
    at_neg();
    chk("R4", "single frame no commit", int'(speed), 0);
    frames(256, 1);
    at_neg();
    chk("R4", "second frame commits", int'(speed), 1);

    frames(259, 3);
    at_neg();
    chk("R5", "bad flag set", int'(bad), 1);
    chk("R5", "speed held on bad", int'(speed), 1);
    frames(256, 3);
    at_neg();
    chk("R5", "bad flag cleared", int'(bad), 0);
    frames(126, 3);
    at_neg();
    chk("R3", "126 edge -> quad", int'(speed), 2);

    // port reset clears history
    @(posedge clk); #2; port_rst = 1'b1; step(2);
    at_neg();
    chk("R7", "adc_pd port reset", int'(adc_pd), 1);
    chk("R7", "speed normal in port reset", int'(speed), 0);
    @(posedge clk); #2; port_rst = 1'b0;
    frames(256, 2);
    at_neg();
    chk("R7", "history cleared", int'(speed), 0);
    frames(256, 1);
    at_neg();
    chk("R7", "commit after rearm", int'(speed), 1);

    step(4);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule